// File: doc/BRIEF.md
# Multicycle Load/Store CPU Control Sequencer

This block is the control unit of a 32-bit processor that runs each instruction over several clock cycles on one shared ALU and one shared memory port. It reads the opcode and function fields of the instruction register and the ALU zero flag. From these it produces, for every cycle, the write enables and multiplexer selects that steer the datapath. The datapath itself is outside the block: the register file, ALU, memory, instruction register, memory data register and ALU-output register. Four instruction classes are supported: register-to-register ALU operations, word load, word store, and branch when two registers are equal.

Every instruction begins with FETCH. FETCH loads the instruction register and advances the PC by 4. It is followed by DECODE, which writes nothing and leaves PC + (sign-extended immediate << 2) in the ALU-output register as the branch target. Leaving DECODE, the sequencer branches on the opcode:
- Branch goes to BR_EXEC and then back to FETCH.
- ALU operations go to R_EXEC, R_WB and FETCH.
- Stores go to ST_ADDR, ST_MEM and FETCH.
- Loads go to LD_ADDR, LD_MEM, LD_WB and FETCH.
- Any other opcode goes from DECODE straight back to FETCH.

The register read ports take IR[25:21] and IR[20:16], and the immediate comes from IR[15:0]. Both are wired in the datapath and need no control.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: `rst` is synchronous and active high. A clock edge with `rst` high places the machine in FETCH, whatever its current state.
- R2: FETCH outputs are `pc_we`=1, `ir_we`=1, `alu_src_a`=0 (PC), `alu_src_b`=01 (constant 4), `alu_op`=000 (add), `pc_src`=0 (live ALU result) and `mem_addr_sel`=0 (PC). All other outputs are 0. The next state is always DECODE.
- R3: DECODE asserts no write enable. It drives `alu_src_a`=0, `alu_src_b`=11 (sign-extended immediate shifted left by 2) and `alu_op`=000.
- R4: Opcode 000100 (branch-equal) goes from DECODE to BR_EXEC. BR_EXEC drives `alu_src_a`=1 (register A), `alu_src_b`=00 (register B), `alu_op`=001 (subtract) and `pc_src`=1 (ALU-output register). It drives `pc_we` equal to `zero`. The next state is FETCH, so a branch takes 3 cycles.
- R5: Opcode 000000 goes to R_EXEC. R_EXEC drives `alu_src_a`=1, `alu_src_b`=00 and an `alu_op` taken from the function field. The mapping is 100000→000 add, 100010→001 sub, 100100→010 and, 100101→011 or, 100110→100 xor, 100111→101 nor, 101010→110 slt. Any other function code gives 000.
- R6: R_WB drives `reg_we`=1, `reg_dst`=1 (Rd, IR[15:11]) and `reg_wdata_sel`=0 (ALU-output register). The next state is FETCH, so an R-type instruction takes 4 cycles.
- R7: Opcode 101011 (store) goes to ST_ADDR and then to ST_MEM. ST_ADDR drives `alu_src_a`=1, `alu_src_b`=10 (sign-extended immediate) and `alu_op`=000. ST_MEM drives `mem_we`=1 and `mem_addr_sel`=1 (ALU-output register), with register B as the write data. A store takes 4 cycles.
- R8: Opcode 100011 (load) goes to LD_ADDR, then LD_MEM, then LD_WB. LD_ADDR has the same outputs as ST_ADDR. LD_MEM drives only `mem_addr_sel`=1. LD_WB drives `reg_we`=1, `reg_dst`=0 (Rt, IR[20:16]) and `reg_wdata_sel`=1 (memory data register). A load takes 5 cycles.
- R9: Any other opcode seen in DECODE returns the machine to FETCH, and no write enable is asserted on the way.
- R10: `ir_we` is high only in FETCH. `mem_we` is high only in ST_MEM. `reg_we` is high only in R_WB and LD_WB. `pc_we` is high only in FETCH and in BR_EXEC with `zero` set.
- R11: Every output that a state does not name above is driven to 0.
- R12: The opcode is used only in DECODE, the function field only in R_EXEC, and `zero` only in BR_EXEC. Their values in any other state change neither the outputs nor the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | IR[31:26] |
| funct | input | 6 | IR[5:0] |
| zero | input | 1 | ALU zero flag |
| pc_we | output | 1 | PC write enable |
| mem_we | output | 1 | Memory write enable |
| reg_we | output | 1 | Register file write enable |
| ir_we | output | 1 | Instruction register write enable |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B: 00 reg B, 01 const 4, 10 sext imm, 11 sext imm<<2 |
| alu_op | output | 3 | ALU operation code |
| reg_dst | output | 1 | Write register: 0 Rt, 1 Rd |
| reg_wdata_sel | output | 1 | Write data: 0 ALU-output register, 1 memory data register |
| pc_src | output | 1 | PC data: 0 live ALU result, 1 ALU-output register |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU-output register |

## Verification
The hardest case to reach is the claim that inputs matter only in their own state. The bench has to present an opcode that disagrees with the running sequence while it is in an execute or write-back state, a zero flag outside BR_EXEC, and a function code outside R_EXEC, and then confirm that nothing moved. The stimulus therefore drives random garbage on every input except the one the current state is defined to consume. It mixes random valid and invalid opcodes, both zero values in BR_EXEC, and every function code. It also raises reset once in the middle of a load.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int OP_W  = 3;
    localparam int SRCB_W = 2;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_BR_EXEC,
        S_R_EXEC, S_R_WB,
        S_ST_ADDR, S_ST_MEM,
        S_LD_ADDR, S_LD_MEM, S_LD_WB
    } ctl_state_t;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    localparam logic [OP_W-1:0] ALU_ADD = 3'd0;
    localparam logic [OP_W-1:0] ALU_SUB = 3'd1;
    localparam logic [OP_W-1:0] ALU_AND = 3'd2;
    localparam logic [OP_W-1:0] ALU_OR  = 3'd3;
    localparam logic [OP_W-1:0] ALU_XOR = 3'd4;
    localparam logic [OP_W-1:0] ALU_NOR = 3'd5;
    localparam logic [OP_W-1:0] ALU_SLT = 3'd6;

    localparam logic [SRCB_W-1:0] SRCB_REG  = 2'd0;
    localparam logic [SRCB_W-1:0] SRCB_FOUR = 2'd1;
    localparam logic [SRCB_W-1:0] SRCB_IMM  = 2'd2;
    localparam logic [SRCB_W-1:0] SRCB_IMM4 = 2'd3;

    typedef struct packed {
        logic              pc_we;
        logic              mem_we;
        logic              reg_we;
        logic              ir_we;
        logic              src_a;
        logic [SRCB_W-1:0] src_b;
        logic [OP_W-1:0]   op;
        logic              rdst;
        logic              wsel;
        logic              pcsrc;
        logic              asel;
    } ctl_word_t;

endpackage

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output ctl_state_t       state
);
    ctl_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = S_FETCH;
        unique case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                unique case (opcode)
                    OPC_RTYPE: nxt = S_R_EXEC;
                    OPC_LOAD:  nxt = S_LD_ADDR;
                    OPC_STORE: nxt = S_ST_ADDR;
                    OPC_BEQ:   nxt = S_BR_EXEC;
                    default:   nxt = S_FETCH;
                endcase
            end
            S_R_EXEC:  nxt = S_R_WB;
            S_ST_ADDR: nxt = S_ST_MEM;
            S_LD_ADDR: nxt = S_LD_MEM;
            S_LD_MEM:  nxt = S_LD_WB;
            S_BR_EXEC, S_R_WB, S_ST_MEM, S_LD_WB: nxt = S_FETCH;
            default:   nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fn_dec.sv
module mc_ctrl_fn_dec
    import mc_ctrl_pkg::*;
(
    input  logic [FN_W-1:0] funct,
    output logic [OP_W-1:0] fn_op
);
    always_comb begin
        unique case (funct)
            6'b100010: fn_op = ALU_SUB;
            6'b100100: fn_op = ALU_AND;
            6'b100101: fn_op = ALU_OR;
            6'b100110: fn_op = ALU_XOR;
            6'b100111: fn_op = ALU_NOR;
            6'b101010: fn_op = ALU_SLT;
            default:   fn_op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
    import mc_ctrl_pkg::*;
(
    input  ctl_state_t      state,
    input  logic            zero,
    input  logic [OP_W-1:0] fn_op,
    output ctl_word_t       ctl
);
    always_comb begin
        ctl = '0;
        unique case (state)
            S_FETCH: begin
                ctl.pc_we = 1'b1;
                ctl.ir_we = 1'b1;
                ctl.src_b = SRCB_FOUR;
                ctl.op    = ALU_ADD;
            end
            S_DECODE: begin
                ctl.src_b = SRCB_IMM4;
                ctl.op    = ALU_ADD;
            end
            S_BR_EXEC: begin
                ctl.src_a = 1'b1;
                ctl.src_b = SRCB_REG;
                ctl.op    = ALU_SUB;
                ctl.pc_we = zero;
                ctl.pcsrc = 1'b1;
            end
            S_R_EXEC: begin
                ctl.src_a = 1'b1;
                ctl.src_b = SRCB_REG;
                ctl.op    = fn_op;
            end
            S_R_WB: begin
                ctl.reg_we = 1'b1;
                ctl.rdst   = 1'b1;
            end
            S_ST_ADDR, S_LD_ADDR: begin
                ctl.src_a = 1'b1;
                ctl.src_b = SRCB_IMM;
                ctl.op    = ALU_ADD;
            end
            S_ST_MEM: begin
                ctl.mem_we = 1'b1;
                ctl.asel   = 1'b1;
            end
            S_LD_MEM: ctl.asel = 1'b1;
            S_LD_WB: begin
                ctl.reg_we = 1'b1;
                ctl.wsel   = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FN_W-1:0]    funct,
    input  logic               zero,
    output logic               pc_we,
    output logic               mem_we,
    output logic               reg_we,
    output logic               ir_we,
    output logic               alu_src_a,
    output logic [SRCB_W-1:0]  alu_src_b,
    output logic [OP_W-1:0]    alu_op,
    output logic               reg_dst,
    output logic               reg_wdata_sel,
    output logic               pc_src,
    output logic               mem_addr_sel
);
    ctl_state_t      state;
    logic [OP_W-1:0] fn_op;
    ctl_word_t       ctl;

    mc_ctrl_seq    u_seq (.clk(clk), .rst(rst), .opcode(opcode), .state(state));
    mc_ctrl_fn_dec u_fn  (.funct(funct), .fn_op(fn_op));
    mc_ctrl_out    u_out (.state(state), .zero(zero), .fn_op(fn_op), .ctl(ctl));

    assign pc_we         = ctl.pc_we;
    assign mem_we        = ctl.mem_we;
    assign reg_we        = ctl.reg_we;
    assign ir_we         = ctl.ir_we;
    assign alu_src_a     = ctl.src_a;
    assign alu_src_b     = ctl.src_b;
    assign alu_op        = ctl.op;
    assign reg_dst       = ctl.rdst;
    assign reg_wdata_sel = ctl.wsel;
    assign pc_src        = ctl.pcsrc;
    assign mem_addr_sel  = ctl.asel;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
    import mc_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              zero,
    input logic              pc_we,
    input logic              mem_we,
    input logic              reg_we,
    input logic              ir_we,
    input logic              alu_src_a,
    input logic [SRCB_W-1:0] alu_src_b,
    input logic [OP_W-1:0]   alu_op,
    input logic              reg_dst,
    input logic              reg_wdata_sel,
    input logic              pc_src,
    input logic              mem_addr_sel
);
    AST_FETCH_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_we && pc_we)); // R1
    AST_DECODE_SILENT: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (!pc_we && !ir_we && !mem_we && !reg_we && alu_src_b == SRCB_IMM4)); // R3
    AST_BRANCH_PC_ZERO: assert property (@(posedge clk) disable iff (rst)
        pc_src |-> (pc_we == zero && alu_op == ALU_SUB)); // R4
    AST_STORE_ADDR: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr_sel && !reg_we && !pc_we)); // R7
    AST_WB_PAIRING: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_dst != reg_wdata_sel)); // R8
    AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({ir_we, mem_we, reg_we}) <= 1); // R10
    AST_NEXT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_we || reg_we) |=> ir_we); // R6
endmodule

bind mc_ctrl_fsm mc_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .zero(zero),
    .pc_we(pc_we), .mem_we(mem_we), .reg_we(reg_we), .ir_we(ir_we),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .reg_dst(reg_dst), .reg_wdata_sel(reg_wdata_sel),
    .pc_src(pc_src), .mem_addr_sel(mem_addr_sel)
);

// File: tb/mc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero = 1'b0;
    logic pc_we, mem_we, reg_we, ir_we, alu_src_a, reg_dst, reg_wdata_sel, pc_src, mem_addr_sel;
    logic [1:0] alu_src_b;
    logic [2:0] alu_op;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
        .pc_we(pc_we), .mem_we(mem_we), .reg_we(reg_we), .ir_we(ir_we),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .reg_dst(reg_dst), .reg_wdata_sel(reg_wdata_sel),
        .pc_src(pc_src), .mem_addr_sel(mem_addr_sel)
    );

    typedef enum int {K_FETCH, K_DEC, K_BR, K_REX, K_RWB, K_SADR, K_SMEM, K_LADR, K_LMEM, K_LWB} kind_t;

    function automatic logic [2:0] fn_to_op(input logic [5:0] f);
        case (f)
            6'b100000: return 3'd0;
            6'b100010: return 3'd1;
            6'b100100: return 3'd2;
            6'b100101: return 3'd3;
            6'b100110: return 3'd4;
            6'b100111: return 3'd5;
            6'b101010: return 3'd6;
            default:   return 3'd0;
        endcase
    endfunction

    // order: pc_we mem_we reg_we ir_we src_a src_b[1:0] op[2:0] rdst wsel pcsrc asel
    function automatic logic [13:0] exp_vec(input kind_t k, input logic [5:0] f, input logic z);
        case (k)
            K_FETCH: return {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0};
            K_DEC:   return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0};
            K_BR:    return {z,    1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0};
            K_REX:   return {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, fn_to_op(f), 1'b0, 1'b0, 1'b0, 1'b0};
            K_RWB:   return {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0};
            K_SADR, K_LADR:
                     return {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0};
            K_SMEM:  return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1};
            K_LMEM:  return {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1};
            K_LWB:   return {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input kind_t k);
        case (k)
            K_FETCH: return "R2";
            K_DEC:   return "R3";
            K_BR:    return "R4";
            K_REX:   return "R5";
            K_RWB:   return "R6";
            K_SADR, K_SMEM: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [13:0] act_vec();
        return {pc_we, mem_we, reg_we, ir_we, alu_src_a, alu_src_b, alu_op,
                reg_dst, reg_wdata_sel, pc_src, mem_addr_sel};
    endfunction

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge with the machine back in FETCH.
    task automatic run_instr(input logic [5:0] opc, input logic [5:0] f, input logic z);
        kind_t seq [5];
        int n;
        seq[0] = K_FETCH; seq[1] = K_DEC;
        case (opc)
            6'b000100: begin seq[2] = K_BR; n = 3; end
            6'b000000: begin seq[2] = K_REX; seq[3] = K_RWB; n = 4; end
            6'b101011: begin seq[2] = K_SADR; seq[3] = K_SMEM; n = 4; end
            6'b100011: begin seq[2] = K_LADR; seq[3] = K_LMEM; seq[4] = K_LWB; n = 5; end
            default:   n = 2;
        endcase
        for (int i = 0; i < n; i++) begin
            // R12: inputs not consumed in this state carry garbage
            opcode = (seq[i] == K_DEC) ? opc : 6'($urandom);
            funct  = (seq[i] == K_REX) ? f : 6'($urandom);
            zero   = (seq[i] == K_BR) ? z : 1'($urandom);
            #1;
            if (n == 2 && i == 1)
                check("R9", act_vec(), exp_vec(seq[i], f, z));
            else
                check((i > 1 && seq[i] != K_REX && seq[i] != K_BR) ? "R12" : req_of(seq[i]),
                      act_vec(), exp_vec(seq[i], f, z));
            @(negedge clk);
        end
        opcode = 6'($urandom);
        #1;
        tests++;
        if (ir_we !== 1'b1) begin
            fails++;
            $display("FAIL %s: cycle count %0d, ir_we actual %b expected 1",
                     (n == 3) ? "R4" : (n == 5) ? "R8" : (n == 2) ? "R9" : "R6", n, ir_we);
        end
    endtask

    function automatic logic [5:0] pick_opc();
        case ($urandom % 5)
            0: return 6'b000000;
            1: return 6'b100011;
            2: return 6'b101011;
            3: return 6'b000100;
            default: begin
                logic [5:0] v;
                v = 6'($urandom);
                if (v == 6'b000000 || v == 6'b100011 || v == 6'b101011 || v == 6'b000100)
                    v = 6'b111111;
                return v;
            end
        endcase
    endfunction

    function automatic logic [5:0] pick_fn();
        logic [5:0] tbl [7] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101,
                                6'b100110, 6'b100111, 6'b101010};
        if ($urandom % 4 == 0) return 6'($urandom);
        return tbl[$urandom % 7];
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", act_vec(), exp_vec(K_FETCH, 6'd0, 1'b0));
        @(negedge clk);
        check("R11", act_vec(), exp_vec(K_DEC, 6'd0, 1'b0));
        // return to FETCH via unknown opcode to align
        opcode = 6'b111111;
        @(negedge clk);
        // directed cases
        run_instr(6'b000100, 6'd0, 1'b1);
        run_instr(6'b000100, 6'd0, 1'b0);
        run_instr(6'b000000, 6'b100000, 1'b0);
        run_instr(6'b000000, 6'b100010, 1'b1);
        run_instr(6'b000000, 6'b100100, 1'b0);
        run_instr(6'b000000, 6'b100101, 1'b0);
        run_instr(6'b000000, 6'b100110, 1'b0);
        run_instr(6'b000000, 6'b100111, 1'b0);
        run_instr(6'b000000, 6'b101010, 1'b0);
        run_instr(6'b000000, 6'b001000, 1'b0);
        run_instr(6'b101011, 6'd0, 1'b1);
        run_instr(6'b100011, 6'd0, 1'b1);
        run_instr(6'b000010, 6'd0, 1'b1);
        run_instr(6'b111111, 6'd0, 1'b0);
        // R1: reset raised in the middle of a load, in LD_MEM
        opcode = 6'b100011; @(negedge clk);   // FETCH -> DECODE
        @(negedge clk);                        // DECODE -> LD_ADDR
        @(negedge clk);                        // LD_ADDR -> LD_MEM
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", act_vec(), exp_vec(K_FETCH, 6'd0, 1'b0));
        @(negedge clk);
        opcode = 6'b111111;
        @(negedge clk);
        // random mix
        for (int t = 0; t < 400; t++)
            run_instr(pick_opc(), pick_fn(), 1'($urandom));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule